// File: doc/BRIEF.md
# Data Address Map Translator

This block turns a logical data address into a physical address in one of three memories, or into an I/O window. The logical data space is cut into fixed 16 KB blocks. Each block has its own 16-bit map register, and that register picks where the block lands. The choices are external unified memory, instruction memory, internal data memory, or a reserved code that faults. The last block can instead be switched into an I/O mode. In that mode, each 4 KB quarter of the block draws a 4-bit window number from one nibble of its map register.

A requester presents an address and a byte count with a valid strobe. One clock later the block returns the physical address, a granted byte count and a fault flag. The granted count is cut short so that an access never runs past the end of its block. A fault returns a zero address and a zero count. The map registers sit on a small register port at their own data addresses, plus one alias address. They come out of reset with fixed values.

Top module: `dmap_xlate`

## Requirements
- R1: After reset, map registers 0, 1 and 2 read 0x2000 and map register 3 reads 0x0000.
- R2: Map register k is read and written at register address 0xFF08 + 2k (k = 0..3). A write with `regWrEn` high takes effect at the next clock edge. `regRdData` shows the addressed register combinationally, and `regHit` is high.
- R3: Register address 0xFF04 is an alias of map register 2 for both reads and writes.
- R4: At any other register address, `regHit` is low and `regRdData` is 0. A write there leaves all four map registers unchanged.
- R5: The block index is address bits 15:14 and the offset is bits 13:0. A logical address of 0x10000 or above faults.
- R6: A map field of 00 in bits 13:12 selects unified memory. The physical address is 0x00000000 + segment × 0x4000 + offset, and the segment is bits 9:0.
- R7: A map field of 01 selects instruction memory. The physical address is 0x01000000 + segment × 0x4000 + offset.
- R8: A map field of 10 selects internal data memory. The physical address is 0x02000000 + (segment << 16) + block index × 0x4000 + offset.
- R9: A map field of 11, outside I/O mode, faults. Any fault returns `rspPhys` = 0 and `rspLen` = 0.
- R10: I/O mode applies when the block index is 3 and bit 15 of map register 3 is set. The sub-range s = offset bits 13:12 picks a nibble, with s = 0 taking bits 15:12, then 11:8, then 7:4, then 3:0. The physical address is 0x02000000 + nibble × 0x10000 + 0xC000 + offset. Bit 15 in any other map register has no such effect.
- R11: The granted length `rspLen` is the smaller of `reqLen` and 0x4000 − offset. A zero `reqLen` grants zero without a fault.
- R12: A request raised at a clock edge yields `rspValid` and its results right after that edge. `rspValid` is low after any edge without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regAddr | input | 16 | Register port address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Addressed map register, 0 on a miss |
| regHit | output | 1 | regAddr decodes to a map register |
| reqValid | input | 1 | Translation request strobe |
| reqAddr | input | 17 | Logical data address |
| reqLen | input | 4 | Requested byte count |
| rspValid | output | 1 | Result valid |
| rspPhys | output | 32 | Physical address |
| rspLen | output | 4 | Granted byte count |
| rspFault | output | 1 | Translation fault |

## Verification
A vector table, walked after the map registers are set up, drives one address into each block. The four blocks are set to unified, instruction, internal data and I/O targets, so a swapped base, segment shift or block-index term shows up as a distinct wrong address. The I/O block is hit once in each 4 KB quarter, which separates nibble order from nibble width. Offsets near 0x3FFF with long requests test clipping, while short and zero-length requests show that the count passes through unchanged. Directed cases then set a reserved target, set bit 15 on a block other than the last, write through the alias address and to unmapped addresses, use the largest segment number, and send addresses above the logical space.

// File: rtl/dmap_xlate_pkg.sv
package dmap_xlate_pkg;

  localparam int STROBE_IDX_W = 4;

  typedef enum logic [1:0] {
    TGT_UNIFIED  = 2'b00,
    TGT_INSN     = 2'b01,
    TGT_DATA     = 2'b10,
    TGT_RESERVED = 2'b11
  } target_e;

  typedef struct packed {
    logic                    hit;
    logic                    mapWr;
    logic [STROBE_IDX_W-1:0] mapIdx;
    logic                    capture;
  } ctlStrobe_t;

endpackage

// File: rtl/dmap_xlate_ctrl.sv
module dmap_xlate_ctrl
  import dmap_xlate_pkg::*;
#(
  parameter int          NMAP        = 4,
  parameter int          RA_W        = 16,
  parameter logic [15:0] MAP_BASE    = 16'hFF08,
  parameter logic [15:0] SHADOW_ADDR = 16'hFF04,
  parameter int          SHADOW_IDX  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] regAddr,
  input  logic            regWrEn,
  input  logic            reqValid,
  output ctlStrobe_t      ctl
);

  logic [NMAP-1:0] match;
  logic            shadowHit;
  logic [STROBE_IDX_W-1:0] encIdx;

  for (genvar i = 0; i < NMAP; i++) begin : g_dec
    localparam logic [RA_W-1:0] SLOT = RA_W'(MAP_BASE) + RA_W'(2 * i);
    assign match[i] = (regAddr == SLOT);
  end

  assign shadowHit = (regAddr == RA_W'(SHADOW_ADDR));

  always_comb begin
    encIdx = '0;
    for (int i = 0; i < NMAP; i++) begin
      if (match[i]) encIdx = STROBE_IDX_W'(i);
    end
    if (shadowHit) encIdx = STROBE_IDX_W'(SHADOW_IDX);
  end

  always_comb begin
    ctl.hit     = (|match) | shadowHit;
    ctl.mapIdx  = encIdx;
    ctl.mapWr   = regWrEn & ((|match) | shadowHit);
    ctl.capture = reqValid;
  end

  p_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == RA_W'(SHADOW_ADDR)) |-> (ctl.hit && ctl.mapIdx == STROBE_IDX_W'(SHADOW_IDX)))
    else $error("alias address did not decode to map register 2");

  p_single_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match))
    else $error("register address matched more than one map slot");

endmodule

// File: rtl/dmap_xlate_dp.sv
module dmap_xlate_dp
  import dmap_xlate_pkg::*;
#(
  parameter int          NMAP       = 4,
  parameter int          MAP_W      = 16,
  parameter int          LOG_W      = 17,
  parameter int          BLK_W      = 14,
  parameter int          LEN_W      = 4,
  parameter int          PHYS_W     = 32,
  parameter logic [31:0] UNI_BASE   = 32'h0000_0000,
  parameter logic [31:0] INSN_BASE  = 32'h0100_0000,
  parameter logic [31:0] DATA_BASE  = 32'h0200_0000,
  parameter logic [31:0] IO_OFS     = 32'h0000_C000,
  parameter logic [15:0] RST_MAP    = 16'h2000,
  parameter logic [15:0] RST_LAST   = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        ctl,
  input  logic [MAP_W-1:0]  regWrData,
  output logic [MAP_W-1:0]  regRdData,
  input  logic [LOG_W-1:0]  reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              rspValid,
  output logic [PHYS_W-1:0] rspPhys,
  output logic [LEN_W-1:0]  rspLen,
  output logic              rspFault
);

  localparam int IDX_W = $clog2(NMAP);
  localparam logic [LOG_W:0] LIMIT = (LOG_W+1)'(NMAP) << BLK_W;
  localparam logic [BLK_W:0] BLK_SIZE = (BLK_W+1)'(1) << BLK_W;
  localparam int SEG_W = 10;
  localparam int SEG_SHIFT_DATA = 16;
  localparam int IO_EN_BIT = 15;

  logic [MAP_W-1:0]      mapReg [NMAP];
  logic [NMAP*MAP_W-1:0] mapFlat;

  for (genvar i = 0; i < NMAP; i++) begin : g_map
    localparam logic [MAP_W-1:0] RVAL = (i == NMAP - 1) ? MAP_W'(RST_LAST) : MAP_W'(RST_MAP);
    logic [MAP_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= RVAL;
      else if (ctl.mapWr && ctl.mapIdx == STROBE_IDX_W'(i)) q <= regWrData;
    end
    assign mapReg[i] = q;
    assign mapFlat[i*MAP_W +: MAP_W] = q;
  end

  assign regRdData = ctl.hit ? mapReg[ctl.mapIdx[IDX_W-1:0]] : '0;

  // Combinational translation
  logic [IDX_W-1:0]  blkIdx;
  logic [BLK_W-1:0]  blkOff;
  logic [MAP_W-1:0]  sel;
  target_e           tgt;
  logic [SEG_W-1:0]  seg;
  logic              inRange, ioMode;
  logic [1:0]        subIdx;
  logic [3:0]        nib;
  logic [PHYS_W-1:0] offExt, physNext;
  logic              faultNext;
  logic [BLK_W:0]    room;
  logic [LEN_W-1:0]  lenNext;

  assign blkIdx  = reqAddr[BLK_W +: IDX_W];
  assign blkOff  = reqAddr[BLK_W-1:0];
  assign sel     = mapReg[blkIdx];
  assign tgt     = target_e'(sel[13:12]);
  assign seg     = sel[SEG_W-1:0];
  assign inRange = ((LOG_W+1)'(reqAddr) < LIMIT);
  assign ioMode  = (blkIdx == IDX_W'(NMAP - 1)) && sel[IO_EN_BIT];
  assign subIdx  = blkOff[BLK_W-1 -: 2];
  assign offExt  = PHYS_W'(blkOff);

  always_comb begin
    case (subIdx)
      2'd0:    nib = sel[15:12];
      2'd1:    nib = sel[11:8];
      2'd2:    nib = sel[7:4];
      default: nib = sel[3:0];
    endcase
  end

  always_comb begin
    physNext  = '0;
    faultNext = 1'b0;
    if (!inRange) begin
      faultNext = 1'b1;
    end else if (ioMode) begin
      physNext = PHYS_W'(DATA_BASE) + (PHYS_W'(nib) << 16) + PHYS_W'(IO_OFS) + offExt;
    end else begin
      case (tgt)
        TGT_UNIFIED: physNext = PHYS_W'(UNI_BASE) + (PHYS_W'(seg) << BLK_W) + offExt;
        TGT_INSN:    physNext = PHYS_W'(INSN_BASE) + (PHYS_W'(seg) << BLK_W) + offExt;
        TGT_DATA:    physNext = PHYS_W'(DATA_BASE) + (PHYS_W'(seg) << SEG_SHIFT_DATA)
                                + (PHYS_W'(blkIdx) << BLK_W) + offExt;
        default:     faultNext = 1'b1;
      endcase
    end
  end

  always_comb begin
    room = BLK_SIZE - {1'b0, blkOff};
    if ((BLK_W+1)'(reqLen) > room) lenNext = room[LEN_W-1:0];
    else                           lenNext = reqLen;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspPhys  <= '0;
      rspLen   <= '0;
      rspFault <= 1'b0;
    end else begin
      rspValid <= ctl.capture;
      if (ctl.capture) begin
        rspFault <= faultNext;
        rspPhys  <= faultNext ? '0 : physNext;
        rspLen   <= faultNext ? '0 : lenNext;
      end
    end
  end

  logic unusedIdxBits;
  assign unusedIdxBits = ^ctl.mapIdx;

  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.capture |=> rspValid)
    else $error("no response after request");

  p_rsp_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.capture |=> !rspValid)
    else $error("response without request");

  p_range_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.capture && (LOG_W+1)'(reqAddr) >= LIMIT) |=> rspFault)
    else $error("out-of-range address did not fault");

  p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspFault) |-> (rspPhys == '0 && rspLen == '0))
    else $error("faulted response carries nonzero fields");

  p_grant_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.capture |=> (rspLen <= $past(reqLen)))
    else $error("granted length exceeds request");

  p_map_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.mapWr |=> $stable(mapFlat))
    else $error("map register changed without a decoded write");

endmodule

// File: rtl/dmap_xlate.sv
module dmap_xlate
  import dmap_xlate_pkg::*;
#(
  parameter int NMAP   = 4,
  parameter int MAP_W  = 16,
  parameter int RA_W   = 16,
  parameter int LOG_W  = 17,
  parameter int BLK_W  = 14,
  parameter int LEN_W  = 4,
  parameter int PHYS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   regAddr,
  input  logic              regWrEn,
  input  logic [MAP_W-1:0]  regWrData,
  output logic [MAP_W-1:0]  regRdData,
  output logic              regHit,
  input  logic              reqValid,
  input  logic [LOG_W-1:0]  reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              rspValid,
  output logic [PHYS_W-1:0] rspPhys,
  output logic [LEN_W-1:0]  rspLen,
  output logic              rspFault
);

  ctlStrobe_t ctl;

  dmap_xlate_ctrl #(
    .NMAP(NMAP), .RA_W(RA_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .reqValid(reqValid), .ctl(ctl)
  );

  dmap_xlate_dp #(
    .NMAP(NMAP), .MAP_W(MAP_W), .LOG_W(LOG_W), .BLK_W(BLK_W),
    .LEN_W(LEN_W), .PHYS_W(PHYS_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .regWrData(regWrData),
    .regRdData(regRdData), .reqAddr(reqAddr), .reqLen(reqLen),
    .rspValid(rspValid), .rspPhys(rspPhys), .rspLen(rspLen), .rspFault(rspFault)
  );

  assign regHit = ctl.hit;

endmodule

// File: tb/dmap_xlate_test.sv
`timescale 1ns/1ps
module dmap_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        regHit;
  logic        reqValid = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [3:0]  reqLen = '0;
  logic        rspValid;
  logic [31:0] rspPhys;
  logic [3:0]  rspLen;
  logic        rspFault;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  dmap_xlate uut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .regHit(regHit),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqLen(reqLen),
    .rspValid(rspValid), .rspPhys(rspPhys), .rspLen(rspLen), .rspFault(rspFault)
  );

  // Vector table: map 0 = unified seg 5, 1 = insn seg 3, 2 = data seg 7, 3 = I/O 0x9ABC
  localparam int NV = 12;
  localparam logic [16:0] V_ADDR [NV] = '{17'h00010, 17'h03FFE, 17'h04000, 17'h07FFF,
                                          17'h08123, 17'h0C004, 17'h0D010, 17'h0E000,
                                          17'h0FFFC, 17'h10000, 17'h1FFFF, 17'h00000};
  localparam logic [3:0]  V_LEN  [NV] = '{4'd4, 4'd4, 4'd8, 4'd3, 4'd2, 4'd4, 4'd4, 4'd4,
                                          4'd8, 4'd4, 4'd4, 4'd0};
  localparam logic [31:0] V_PHYS [NV] = '{32'h0001_4010, 32'h0001_7FFE, 32'h0100_C000,
                                          32'h0100_FFFF, 32'h0207_8123, 32'h0209_C004,
                                          32'h020A_D010, 32'h020B_E000, 32'h020C_FFFC,
                                          32'h0000_0000, 32'h0000_0000, 32'h0001_4000};
  localparam logic [3:0]  V_GLEN [NV] = '{4'd4, 4'd2, 4'd8, 4'd1, 4'd2, 4'd4, 4'd4, 4'd4,
                                          4'd4, 4'd0, 4'd0, 4'd0};
  localparam logic        V_FLT  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                          1'b0, 1'b1, 1'b1, 1'b0};
  localparam string       V_TAG  [NV] = '{"R6", "R11", "R7", "R11", "R8", "R10", "R10",
                                          "R10", "R11", "R5", "R5", "R11"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [15:0] a, output logic [15:0] d, output logic h);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData; h = regHit;
  endtask

  task automatic doReq(input logic [16:0] a, input logic [3:0] l);
    @(negedge clk);
    reqAddr = a; reqLen = l; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectRsp(input string tag, input logic [31:0] p, input logic [3:0] l,
                           input logic f);
    check({tag, " valid"}, 32'(rspValid), 32'd1);
    check({tag, " phys"},  rspPhys, p);
    check({tag, " len"},   32'(rspLen), 32'(l));
    check({tag, " fault"}, 32'(rspFault), 32'(f));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic        h;
    repeat (3) @(negedge clk);
    check("R12 reset valid", 32'(rspValid), 32'd0);
    rst_n = 1'b1;

    // R1 reset values and R2 address map
    for (int k = 0; k < 4; k++) begin
      rdReg(16'hFF08 + 16'(2 * k), d, h);
      check("R1 reset map value", 32'(d), (k == 3) ? 32'h0000 : 32'h2000);
      check("R2 map hit", 32'(h), 32'd1);
    end
    rdReg(16'hFF04, d, h);
    check("R3 alias reset read", 32'(d), 32'h2000);

    // R8 reset mapping: block 1 internal data seg 0; block 3 unified seg 0
    doReq(17'h04010, 4'd4);
    expectRsp("R8 reset block1", 32'h0200_4010, 4'd4, 1'b0);
    doReq(17'h0C020, 4'd2);
    expectRsp("R6 reset block3", 32'h0000_0020, 4'd2, 1'b0);

    // Configure map
    wrReg(16'hFF08, 16'h0005);
    wrReg(16'hFF0A, 16'h1003);
    wrReg(16'hFF04, 16'h2007);
    wrReg(16'hFF0E, 16'h9ABC);
    rdReg(16'hFF0C, d, h);
    check("R3 alias write lands in map 2", 32'(d), 32'h2007);
    rdReg(16'hFF0E, d, h);
    check("R2 map 3 write", 32'(d), 32'h9ABC);

    for (int i = 0; i < NV; i++) begin
      doReq(V_ADDR[i], V_LEN[i]);
      expectRsp(V_TAG[i], V_PHYS[i], V_GLEN[i], V_FLT[i]);
    end

    // R12: no request, no response
    @(negedge clk);
    check("R12 idle", 32'(rspValid), 32'd0);

    // R4: unmapped writes ignored
    wrReg(16'hFF06, 16'hFFFF);
    wrReg(16'hFF10, 16'hFFFF);
    wrReg(16'h0000, 16'hFFFF);
    rdReg(16'hFF06, d, h);
    check("R4 miss hit flag", 32'(h), 32'd0);
    check("R4 miss read data", 32'(d), 32'd0);
    rdReg(16'hFF08, d, h);
    check("R4 map0 unchanged", 32'(d), 32'h0005);
    rdReg(16'hFF0A, d, h);
    check("R4 map1 unchanged", 32'(d), 32'h1003);
    rdReg(16'hFF0C, d, h);
    check("R4 map2 unchanged", 32'(d), 32'h2007);
    rdReg(16'hFF0E, d, h);
    check("R4 map3 unchanged", 32'(d), 32'h9ABC);

    // R9: reserved target faults
    wrReg(16'hFF08, 16'h3000);
    doReq(17'h00010, 4'd4);
    expectRsp("R9 reserved", 32'h0, 4'd0, 1'b1);

    // R10: bit 15 on block 0 does not select I/O
    wrReg(16'hFF08, 16'h8005);
    doReq(17'h00010, 4'd4);
    expectRsp("R10 no io on block0", 32'h0001_4010, 4'd4, 1'b0);

    // R8: block 3 without I/O enable uses its target
    wrReg(16'hFF0E, 16'h2001);
    doReq(17'h0C004, 4'd4);
    expectRsp("R8 block3 data", 32'h0201_C004, 4'd4, 1'b0);

    // R7: largest segment number
    wrReg(16'hFF0A, 16'h13FF);
    doReq(17'h04008, 4'd15);
    expectRsp("R7 max segment", 32'h01FF_C008, 4'd15, 1'b0);

    // R11: clip at the last byte of a block
    doReq(17'h07FFF, 4'd15);
    expectRsp("R11 clip to one", 32'h01FF_FFFF, 4'd1, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule